// File: doc/BRIEF.md
# PLL Lock Status Tracker

This block decides when a clock multiplier counts as locked and shows the result in an 8-bit status byte. A frequency comparator drives a raw in-tolerance level. The tracker qualifies that level over a programmable number of consecutive cycles, and only then raises a live lock bit. Lock is forced low in three cases: a divider is reprogrammed, the device enters a stop state that does not keep the multiplier running, or the operating mode does not call for lock detection.

Once lock has been reached, the first drop of the in-tolerance level sets a sticky loss-of-lock flag. Software clears the flag by writing 1 to its bit. While the interrupt enable is set, the flag drives an interrupt request. The tracker also gates the multiplied clock off until lock holds. Two clock-source select bits are re-timed through synchronizer chains, so their status copies trail the control bits by two clocks.

Top module: `pll_lock_tracker`

## Requirements
- R1: `lock` rises after the edge on which `in_tol` has been sampled high for LOCK_CNT consecutive cycles (default 16). A single low sample clears `lock` on the next edge and restarts the count.
- R2: A loss-of-lock event is a cycle in which `lock` is 1 and `in_tol` is 0, with detection active and neither a divider write nor a stop kill present. Such a cycle sets status bit 7 on the next edge. `in_tol` drops before any lock has been reached do not set bit 7.
- R3: A status write (`st_wr` high) with `st_wdata[7]`=1 clears bit 7. A write with `st_wdata[7]`=0 leaves it unchanged. When a clear and a new event land in the same cycle, the bit stays set.
- R4: `lol_irq` is 1 exactly when status bit 7 is 1 and `lol_irq_en` is 1.
- R5: A `div_wr` pulse clears `lock` on the next edge without setting bit 7. Lock then needs a full new run of LOCK_CNT high samples.
- R6: While `stop_req`=1 and `stop_keep`=0, `lock` stays 0. After stop exits, lock needs a full new run. With `stop_keep`=1, stop has no effect on lock.
- R7: `op_mode` encoding: 0–3 are frequency-locked-loop modes, 4 is PLL-bypassed-external, 5 is PLL-engaged, 6 is low-power bypassed internal and 7 is low-power bypassed external. Detection is active in modes 4 and 5, and in modes 0–3 when `pll_clk_en`=1. It is never active in modes 6 and 7. While detection is inactive, `lock` is 0.
- R8: `pll_clk_gate` is 1 only when detection is active and `lock` is 1.
- R9: Status bit 5 copies `psel_ctl` and status bit 4 copies `iref_ctl`. Each changes on exactly the second rising edge after its control bit changes.
- R10: Status layout is {loss-of-lock, lock, PLL-select copy, internal-ref copy, 4'b0}. After reset the status reads 8'h10, and `lol_irq` and `pll_clk_gate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tol | input | 1 | Raw in-tolerance level from the frequency comparator |
| op_mode | input | 3 | Operating mode code (see R7) |
| pll_clk_en | input | 1 | Keeps the PLL running outside PLL-driven modes |
| div_wr | input | 1 | Strobe: a divider field was written |
| stop_req | input | 1 | Device is in a stop state |
| stop_keep | input | 1 | Keep the PLL running during stop |
| lol_irq_en | input | 1 | Loss-of-lock interrupt enable |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data (bit 7 is write-1-to-clear) |
| psel_ctl | input | 1 | PLL-select control bit |
| iref_ctl | input | 1 | Internal-reference control bit |
| status | output | 8 | Status byte |
| lol_irq | output | 1 | Loss-of-lock interrupt request |
| pll_clk_gate | output | 1 | Enable for the multiplied clock |

## Verification
The assertions assume that `in_tol`, `div_wr` and the stop inputs are already synchronous to `clk`. They also assume that a divider write or a stop kill has priority over an in-tolerance drop in the same cycle. The synchronizer check assumes each control bit holds for at least two cycles after reset before its copy is compared. The stimulus changes every input only at the falling edge. It leaves several idle cycles after each select-bit toggle, and it never combines a kill with a tolerance drop except where that priority is the thing under test.

// File: rtl/pll_lock_pkg.sv
// Package: shared mode codes, status bit positions and the detect-enable rule
// for the lock tracker. Assumes a 3-bit mode code.
package pll_lock_pkg;

    typedef enum logic [2:0] {
        MODE_FLL_INT     = 3'd0,
        MODE_FLL_EXT     = 3'd1,
        MODE_FLL_BYP_INT = 3'd2,
        MODE_FLL_BYP_EXT = 3'd3,
        MODE_PLL_BYP     = 3'd4,
        MODE_PLL_RUN     = 3'd5,
        MODE_LP_INT      = 3'd6,
        MODE_LP_EXT      = 3'd7
    } op_mode_e;

    localparam int ST_LOL  = 7;
    localparam int ST_LOCK = 6;
    localparam int ST_PSEL = 5;
    localparam int ST_IREF = 4;

    // Detection runs in PLL-driven modes, or when kept on outside low-power bypass.
    function automatic logic detect_active(op_mode_e m, logic keep_on);
        logic pll_mode;
        logic lp_mode;
        pll_mode = (m == MODE_PLL_BYP) || (m == MODE_PLL_RUN);
        lp_mode  = (m == MODE_LP_INT) || (m == MODE_LP_EXT);
        return pll_mode || (keep_on && !lp_mode);
    endfunction

endpackage

// File: rtl/lock_qualifier.sv
// lock_qualifier: counts consecutive in-tolerance samples and declares lock
// after LOCK_CNT of them. Any drop, divider write, stop kill or inactive
// detection clears the count and the lock. Also flags a loss-of-lock event.
// Assumes all inputs are synchronous to clk.
module lock_qualifier #(
    parameter int LOCK_CNT = 16,
    localparam int CNT_W = (LOCK_CNT > 1) ? $clog2(LOCK_CNT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tol,
    input  logic active,
    input  logic div_wr,
    input  logic stop_kill,
    output logic lock_o,
    output logic lose_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CNT - 1);

    logic [CNT_W-1:0] run_q;
    logic             lock_q;
    logic             kill;

    assign kill = !active || div_wr || stop_kill;

    // Qualification counter and lock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (kill || !in_tol) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (run_q == LAST) begin
            lock_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign lock_o = lock_q;
    assign lose_o = lock_q && !in_tol && !kill;

    assert_drop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tol |=> !lock_o);
    assert_rise_needs_tol_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(in_tol));
    assert_div_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !lock_o);
    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_kill |=> !lock_o);
    assert_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !lock_o);

endmodule

// File: rtl/lol_sticky.sv
// lol_sticky: sticky loss-of-lock flag. It is set by an event and cleared by a
// write-1 strobe; a set in the same cycle as a clear wins. Assumes
// single-cycle strobes.
module lol_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_i || (flag_q && !clr_i);
    end

    assign flag_o = flag_q;

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/sel_sync.sv
// sel_sync: STAGES-deep flop chain that re-times a control bit into the status
// domain. RST_VAL is the reset value of every stage. Assumes the input holds
// long enough to be sampled.
module sel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the control bit through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

    // Count edges since reset, only for the lag check below.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lag_chk
            assert_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd2) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/pll_lock_tracker.sv
// pll_lock_tracker: top level. Decodes the detect enable, qualifies lock,
// keeps the sticky loss-of-lock flag, re-times the select bits and assembles
// the status byte. Assumes all inputs are synchronous to clk.
module pll_lock_tracker
    import pll_lock_pkg::*;
#(
    parameter int LOCK_CNT    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_tol,
    input  logic [2:0] op_mode,
    input  logic       pll_clk_en,
    input  logic       div_wr,
    input  logic       stop_req,
    input  logic       stop_keep,
    input  logic       lol_irq_en,
    input  logic       st_wr,
    input  logic [7:0] st_wdata,
    input  logic       psel_ctl,
    input  logic       iref_ctl,
    output logic [7:0] status,
    output logic       lol_irq,
    output logic       pll_clk_gate
);

    logic active, stop_kill, lock, lose, lol, psel_s, iref_s, clr;

    assign active    = detect_active(op_mode_e'(op_mode), pll_clk_en);
    assign stop_kill = stop_req && !stop_keep;
    assign clr       = st_wr && st_wdata[ST_LOL];

    lock_qualifier #(.LOCK_CNT(LOCK_CNT)) u_qual (
        .clk(clk), .rst_n(rst_n), .in_tol(in_tol), .active(active),
        .div_wr(div_wr), .stop_kill(stop_kill), .lock_o(lock), .lose_o(lose)
    );

    lol_sticky u_lol (
        .clk(clk), .rst_n(rst_n), .set_i(lose), .clr_i(clr), .flag_o(lol)
    );

    sel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_psel (
        .clk(clk), .rst_n(rst_n), .d(psel_ctl), .q(psel_s)
    );

    sel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_iref (
        .clk(clk), .rst_n(rst_n), .d(iref_ctl), .q(iref_s)
    );

    // Assemble the status byte.
    always_comb begin
        status          = '0;
        status[ST_LOL]  = lol;
        status[ST_LOCK] = lock;
        status[ST_PSEL] = psel_s;
        status[ST_IREF] = iref_s;
    end

    assign lol_irq      = lol && lol_irq_en;
    assign pll_clk_gate = active && lock;

    assert_gate_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_clk_gate |-> status[ST_LOCK]);
    assert_irq_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lol_irq |-> (status[ST_LOL] && lol_irq_en));

endmodule

// File: tb/tb_pll_lock_tracker.sv
module tb_pll_lock_tracker;

    localparam int L = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_tol = 1'b0;
    logic [2:0] op_mode = 3'd5;
    logic pll_clk_en = 1'b0, div_wr = 1'b0, stop_req = 1'b0, stop_keep = 1'b0;
    logic lol_irq_en = 1'b0, st_wr = 1'b0, psel_ctl = 1'b0, iref_ctl = 1'b1;
    logic [7:0] st_wdata = 8'h00;
    logic [7:0] status;
    logic lol_irq, pll_clk_gate;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_lock_tracker #(.LOCK_CNT(L), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .in_tol(in_tol), .op_mode(op_mode),
        .pll_clk_en(pll_clk_en), .div_wr(div_wr), .stop_req(stop_req),
        .stop_keep(stop_keep), .lol_irq_en(lol_irq_en), .st_wr(st_wr),
        .st_wdata(st_wdata), .psel_ctl(psel_ctl), .iref_ctl(iref_ctl),
        .status(status), .lol_irq(lol_irq), .pll_clk_gate(pll_clk_gate)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_lol();
        st_wr = 1'b1; st_wdata = 8'h80; cyc(1); st_wr = 1'b0; st_wdata = 8'h00;
    endtask

    task automatic acquire();
        in_tol = 1'b1; cyc(L);
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        // R10 reset state
        chk("R10 reset status", status, 8'h10);
        chk("R10 reset irq/gate", {6'd0, lol_irq, pll_clk_gate}, 8'h00);
        rst_n = 1'b1;
        cyc(1);

        // R1 sweep of run lengths
        for (int k = 1; k <= L + 2; k++) begin
            in_tol = 1'b1; cyc(k);
            chk("R1 lock after run", {7'd0, status[6]}, {7'd0, k >= L});
            chk("R8 gate follows lock", {7'd0, pll_clk_gate}, {7'd0, k >= L});
            in_tol = 1'b0; cyc(1);
            chk("R1 drop clears lock", {7'd0, status[6]}, 8'h00);
            clear_lol();
        end
        // R1 restart on drop
        in_tol = 1'b1; cyc(L - 1); in_tol = 1'b0; cyc(1);
        in_tol = 1'b1; cyc(L - 1);
        chk("R1 restart after drop", {7'd0, status[6]}, 8'h00);
        cyc(1);
        chk("R1 lock after full rerun", {7'd0, status[6]}, 8'h01);
        in_tol = 1'b0; cyc(1); clear_lol();

        // R2 no arming before lock
        for (int k = 0; k < 6; k++) begin in_tol = k[0]; cyc(1); end
        in_tol = 1'b0; cyc(1);
        chk("R2 unarmed drop", {7'd0, status[7]}, 8'h00);

        // R2 R4 loss sets flag and irq
        lol_irq_en = 1'b1;
        acquire(); in_tol = 1'b0; cyc(1);
        chk("R2 loss sets flag", status & 8'hC0, 8'h80);
        chk("R4 irq with enable", {7'd0, lol_irq}, 8'h01);
        // R3 write zero ignored
        st_wr = 1'b1; st_wdata = 8'h7F; cyc(1); st_wr = 1'b0; cyc(2);
        chk("R3 write 0 no effect", {7'd0, status[7]}, 8'h01);
        lol_irq_en = 1'b0; #1;
        chk("R4 irq masked", {7'd0, lol_irq}, 8'h00);
        clear_lol();
        chk("R3 write 1 clears", {7'd0, status[7]}, 8'h00);
        // R3 set wins over clear
        acquire(); in_tol = 1'b0; st_wr = 1'b1; st_wdata = 8'h80; cyc(1);
        st_wr = 1'b0; st_wdata = 8'h00;
        chk("R3 set beats clear", {7'd0, status[7]}, 8'h01);
        clear_lol();

        // R5 divider write
        acquire(); div_wr = 1'b1; cyc(1); div_wr = 1'b0;
        chk("R5 div write clears lock", status & 8'hC0, 8'h00);
        cyc(L - 1);
        chk("R5 still requalifying", {7'd0, status[6]}, 8'h00);
        cyc(1);
        chk("R5 relock after full run", {7'd0, status[6]}, 8'h01);

        // R6 stop without keep
        stop_req = 1'b1; cyc(L + 2);
        chk("R6 stop holds lock low", status & 8'hC0, 8'h00);
        stop_req = 1'b0; cyc(L - 1);
        chk("R6 requalify after stop", {7'd0, status[6]}, 8'h00);
        cyc(1);
        chk("R6 relock after stop", {7'd0, status[6]}, 8'h01);
        stop_keep = 1'b1; stop_req = 1'b1; cyc(3);
        chk("R6 stop with keep", {7'd0, status[6]}, 8'h01);
        stop_req = 1'b0; stop_keep = 1'b0;

        // R7 R8 mode sweep, tolerance held high
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 2; e++) begin
                logic exp_act;
                op_mode = m[2:0]; pll_clk_en = e[0];
                exp_act = (m == 4 || m == 5) || (e == 1 && m < 6);
                cyc(L + 1);
                chk($sformatf("R7 mode %0d en %0d lock", m, e),
                    {7'd0, status[6]}, {7'd0, exp_act});
                chk($sformatf("R8 mode %0d en %0d gate", m, e),
                    {7'd0, pll_clk_gate}, {7'd0, exp_act});
            end
        end
        chk("R7 mode exits set no flag", {7'd0, status[7]}, 8'h00);
        op_mode = 3'd5; pll_clk_en = 1'b0;

        // R9 two-edge lag for both select bits, both directions
        for (int t = 0; t < 4; t++) begin
            logic [1:0] old_v, new_v;
            old_v = status[5:4];
            if (t[0]) iref_ctl = ~iref_ctl; else psel_ctl = ~psel_ctl;
            new_v = {psel_ctl, iref_ctl};
            cyc(1);
            chk("R9 unchanged after one edge", {6'd0, status[5:4]}, {6'd0, old_v});
            cyc(1);
            chk("R9 updated after two edges", {6'd0, status[5:4]}, {6'd0, new_v});
            cyc(2);
        end
        chk("R10 low nibble zero", {4'd0, status[3:0]}, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule